// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Detection

This block is the digital serial port of a telephony voice codec. Once per frame (nominally 8 kHz) it sends one 8-bit companded sample and receives one, sign bit first. The bit clock may run from 64 kHz to 2.048 MHz. All port inputs are oversampled by a faster system clock `clk`, so every bit-clock and sync edge is seen as a one-cycle event inside a single synchronous domain. The transmit line is modelled as a data bit plus an output enable, and an active-low slot indicator marks the transmit time slot.

Two sync styles are supported. A short sync is one bit period wide and precedes the slot. A long sync is three or more bit periods wide and overlaps the slot. The port measures every transmit sync pulse in falling bit-clock edges and keeps a mode register. The mode is used from the next frame on, and both engines freeze it for a frame at their start event.

The transmit engine has five states:
- TX_IDLE waits for a start event.
- TX_ARMED waits for the enabling rising edge.
- TX_SHIFT drives bits.
- TX_DRAIN holds the last bit until a falling edge.
- TX_HOLD keeps a long-sync slot on while sync stays high.

Its transitions are:
- start-short (TX_IDLE to TX_ARMED)
- start-long-late or start-long-now (TX_IDLE to TX_ARMED or TX_SHIFT)
- enable (TX_ARMED to TX_SHIFT)
- last-bit (TX_SHIFT to TX_DRAIN)
- release (TX_DRAIN to TX_IDLE)
- stretch (TX_DRAIN to TX_HOLD)
- sync-drop (TX_HOLD to TX_IDLE)

The receive engine has two states. RX_IDLE moves to RX_CAPTURE on the arm transition, and RX_CAPTURE returns to RX_IDLE on the complete transition.

Top module: `pcm_serial_port`

## Requirements
- R1: While `rst_n` is low and after it, `tx_oe`=0, `tx_slot_n`=1, `rx_valid`=0 and `rx_lsb_lost`=0, and the sync mode is short.
- R2: In short mode, if `tx_fs` is high at a falling `bclk` edge, `tx_oe` rises at the next rising `bclk` edge and `tx_sdata` carries bit 7 of the loaded word.
- R3: In short mode, each of the next seven rising edges drives the next lower bit (bit 6 down to bit 0), and `tx_oe` drops at the falling edge that follows the eighth rising edge.
- R4: In long mode, `tx_oe` rises at the later of the `tx_fs` rising edge and a rising `bclk` edge, with bit 7 first, and the next seven rising edges drive bits 6 to 0.
- R5: In long mode, `tx_oe` drops at the later of two events: the falling edge after the eighth rising edge, or `tx_fs` going low.
- R6: A `tx_fs` pulse high on exactly one falling edge selects short mode, one high on three or more selects long mode, and one high on exactly two leaves the mode unchanged. The new mode applies from the next frame.
- R7: In short mode, if `rx_fs` is high at a falling edge, the next eight falling edges capture `rx_sdata`, MSB first.
- R8: In long mode, a rising `rx_fs` edge causes the next eight falling edges (not one coincident with it) to capture `rx_sdata`, MSB first.
- R9: After the eighth capture, `rx_word` presents the byte and `rx_valid` pulses high for exactly one `clk` cycle, once per frame.
- R10: `rx_lsb_lost` is updated with each `rx_valid`. It is 1 when that frame's `rx_fs` was high on exactly two falling edges, else 0.
- R11: `tx_slot_n` is low exactly while `tx_oe` is high.
- R12: `tx_word` is loaded at the start event. Later changes to it do not alter the byte sent in that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock |
| tx_fs | input | 1 | Transmit frame sync |
| rx_fs | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Serial receive data |
| tx_word | input | 8 | Parallel byte to send next slot |
| tx_sdata | output | 1 | Serial transmit data (valid while tx_oe) |
| tx_oe | output | 1 | Transmit output enable (0 = high impedance) |
| tx_slot_n | output | 1 | Active-low transmit slot indicator |
| rx_word | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |
| rx_lsb_lost | output | 1 | Received byte's LSB position was taken by sync |

## Verification
A wrong mode register shows up on the very next frame. The enable then moves by a full bit period, either from the rising edge at the sync to the following one or back. The disable also moves between the eighth falling edge and the drop of sync. A stuck shift counter or a missing load shows up within the same slot as a wrong bit at one rising edge, or as an enable that lasts seven or nine bit periods. A bad receive state shows up within eight falling edges as a shifted byte, a missing or repeated `rx_valid`, or a stale `rx_lsb_lost`.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

    typedef enum logic {
        SYNC_SHORT = 1'b0,
        SYNC_LONG  = 1'b1
    } sync_mode_t;

    typedef enum logic [2:0] {
        TX_IDLE  = 3'd0,
        TX_ARMED = 3'd1,
        TX_SHIFT = 3'd2,
        TX_DRAIN = 3'd3,
        TX_HOLD  = 3'd4
    } tx_state_t;

    typedef enum logic {
        RX_IDLE    = 1'b0,
        RX_CAPTURE = 1'b1
    } rx_state_t;

endpackage

// File: rtl/pcm_edge_sampler.sv
module pcm_edge_sampler #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] cur_q;
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= raw;
            prev_q <= cur_q;
        end
    end

    always_comb begin
        lvl  = cur_q;
        rise = cur_q & ~prev_q;
        fall = ~cur_q & prev_q;
    end
endmodule

// File: rtl/pcm_fs_meter.sv
module pcm_fs_meter #(
    parameter int CAP = 3,
    localparam int W = $clog2(CAP + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs_lvl,
    input  logic         fs_rise,
    input  logic         fs_fall,
    input  logic         bclk_fall,
    output logic [W-1:0] width,
    output logic         done
);
    logic [W-1:0] cnt_q;

    // Counts falling bit-clock edges seen while sync is high, saturating at CAP
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fs_rise) begin
            cnt_q <= bclk_fall ? W'(1) : '0;
        end else if (bclk_fall && fs_lvl && (cnt_q < W'(CAP))) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    always_comb begin
        width = cnt_q;
        done  = fs_fall;
    end
endmodule

// File: rtl/pcm_tx_engine.sv
module pcm_tx_engine
    import pcm_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_lvl,
    input  logic              bclk_rise,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_rise,
    input  sync_mode_t        mode_in,
    input  logic [WORD_W-1:0] word_in,
    output logic              oe,
    output logic              sdata
);
    localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(WORD_W - 1);

    tx_state_t         state_q, state_d;
    sync_mode_t        frame_mode_q;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  rise_cnt_q;
    logic              do_load, do_start, do_shift;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        do_load  = 1'b0;
        do_start = 1'b0;
        do_shift = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (mode_in == SYNC_SHORT) begin
                    if (bclk_fall && fs_lvl) begin          // start-short
                        do_load = 1'b1;
                        state_d = TX_ARMED;
                    end
                end else if (fs_rise) begin
                    do_load = 1'b1;
                    if (bclk_lvl) begin                     // start-long-now
                        do_start = 1'b1;
                        state_d  = TX_SHIFT;
                    end else begin                          // start-long-late
                        state_d  = TX_ARMED;
                    end
                end
            end
            TX_ARMED: begin
                if (bclk_rise) begin                        // enable
                    do_start = 1'b1;
                    state_d  = TX_SHIFT;
                end
            end
            TX_SHIFT: begin
                if (bclk_rise) begin
                    do_shift = 1'b1;
                    if (rise_cnt_q == LAST_RISE) state_d = TX_DRAIN;  // last-bit
                end
            end
            TX_DRAIN: begin
                if (bclk_fall) begin
                    if (frame_mode_q == SYNC_LONG && fs_lvl) state_d = TX_HOLD;  // stretch
                    else                                     state_d = TX_IDLE;  // release
                end
            end
            TX_HOLD: begin
                if (!fs_lvl) state_d = TX_IDLE;             // sync-drop
            end
            default: state_d = TX_IDLE;
        endcase
    end

    // Datapath: word, frozen mode and rising-edge count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q      <= '0;
            rise_cnt_q   <= '0;
            frame_mode_q <= SYNC_SHORT;
        end else begin
            if (do_load) begin
                shreg_q      <= word_in;
                frame_mode_q <= mode_in;
            end
            if (do_start) begin
                rise_cnt_q <= CNT_W'(1);
            end else if (do_shift) begin
                rise_cnt_q <= rise_cnt_q + CNT_W'(1);
                shreg_q    <= {shreg_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    // Outputs
    always_comb begin
        oe    = (state_q == TX_SHIFT) || (state_q == TX_DRAIN) || (state_q == TX_HOLD);
        sdata = oe ? shreg_q[WORD_W-1] : 1'b0;
    end
endmodule

// File: rtl/pcm_rx_engine.sv
module pcm_rx_engine
    import pcm_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int MW          = 2,
    parameter int LOST_SYNC_W = 2,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall,
    input  logic              fs_lvl,
    input  logic              fs_rise,
    input  sync_mode_t        mode_in,
    input  logic              sdata,
    input  logic              meter_done,
    input  logic [MW-1:0]     meter_width,
    output logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              lsb_lost
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              lost_pend_q;
    logic              do_arm, do_take, do_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        do_arm  = 1'b0;
        do_take = 1'b0;
        do_done = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                if ((mode_in == SYNC_SHORT && bclk_fall && fs_lvl) ||
                    (mode_in == SYNC_LONG && fs_rise)) begin   // arm
                    do_arm  = 1'b1;
                    state_d = RX_CAPTURE;
                end
            end
            RX_CAPTURE: begin
                if (bclk_fall) begin
                    do_take = 1'b1;
                    if (cnt_q == LAST_BIT) begin               // complete
                        do_done = 1'b1;
                        state_d = RX_IDLE;
                    end
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // Shift register, bit count and lost-LSB bookkeeping for the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            cnt_q       <= '0;
            lost_pend_q <= 1'b0;
        end else begin
            if (do_arm) cnt_q <= '0;
            else if (do_take) begin
                cnt_q   <= cnt_q + CNT_W'(1);
                shreg_q <= {shreg_q[WORD_W-2:0], sdata};
            end
            if (fs_rise)         lost_pend_q <= 1'b0;
            else if (meter_done) lost_pend_q <= (meter_width == MW'(LOST_SYNC_W));
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word     <= '0;
            valid    <= 1'b0;
            lsb_lost <= 1'b0;
        end else begin
            valid <= do_done;
            if (do_done) begin
                word     <= {shreg_q[WORD_W-2:0], sdata};
                lsb_lost <= lost_pend_q;
            end
        end
    end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int LONG_MIN    = 3,
    parameter int LOST_SYNC_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk,
    input  logic              tx_fs,
    input  logic              rx_fs,
    input  logic              rx_sdata,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_sdata,
    output logic              tx_oe,
    output logic              tx_slot_n,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_lsb_lost
);
    localparam int MW      = $clog2(LONG_MIN + 1);
    localparam int N_SYNC  = 2;
    localparam int IDX_TX  = 0;
    localparam int IDX_RX  = 1;

    logic [2:0] s_lvl, s_rise, s_fall;
    logic       bclk_lvl, bclk_rise, bclk_fall;
    logic       txfs_lvl, txfs_rise, txfs_fall;
    logic       rxfs_lvl, rxfs_rise;
    logic       rxd_q;
    sync_mode_t sync_mode;

    logic [N_SYNC-1:0] fs_lvl_v, fs_rise_v, fs_fall_v, meter_done;
    logic [MW-1:0]     meter_width [N_SYNC];

    pcm_edge_sampler #(.N(3)) u_sampler (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  ({rx_fs, tx_fs, bclk}),
        .lvl  (s_lvl),
        .rise (s_rise),
        .fall (s_fall)
    );

    // Data sample aligned with the edge sampler's level stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rxd_q <= 1'b0;
        else        rxd_q <= rx_sdata;
    end

    always_comb begin
        bclk_lvl  = s_lvl[0];
        bclk_rise = s_rise[0];
        bclk_fall = s_fall[0];
        txfs_lvl  = s_lvl[1];
        txfs_rise = s_rise[1];
        txfs_fall = s_fall[1];
        rxfs_lvl  = s_lvl[2];
        rxfs_rise = s_rise[2];
        fs_lvl_v  = s_lvl[2:1];
        fs_rise_v = s_rise[2:1];
        fs_fall_v = s_fall[2:1];
    end

    generate
        for (genvar g = 0; g < N_SYNC; g++) begin : g_meter
            pcm_fs_meter #(.CAP(LONG_MIN)) u_meter (
                .clk      (clk),
                .rst_n    (rst_n),
                .fs_lvl   (fs_lvl_v[g]),
                .fs_rise  (fs_rise_v[g]),
                .fs_fall  (fs_fall_v[g]),
                .bclk_fall(bclk_fall),
                .width    (meter_width[g]),
                .done     (meter_done[g])
            );
        end
    endgenerate

    // Sync mode register: short after reset, reclassified at each transmit sync end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_mode <= SYNC_SHORT;
        end else if (meter_done[IDX_TX]) begin
            if (meter_width[IDX_TX] == MW'(1))             sync_mode <= SYNC_SHORT;
            else if (meter_width[IDX_TX] >= MW'(LONG_MIN)) sync_mode <= SYNC_LONG;
        end
    end

    pcm_tx_engine #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_lvl (bclk_lvl),
        .bclk_rise(bclk_rise),
        .bclk_fall(bclk_fall),
        .fs_lvl   (txfs_lvl),
        .fs_rise  (txfs_rise),
        .mode_in  (sync_mode),
        .word_in  (tx_word),
        .oe       (tx_oe),
        .sdata    (tx_sdata)
    );

    pcm_rx_engine #(.WORD_W(WORD_W), .MW(MW), .LOST_SYNC_W(LOST_SYNC_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk_fall  (bclk_fall),
        .fs_lvl     (rxfs_lvl),
        .fs_rise    (rxfs_rise),
        .mode_in    (sync_mode),
        .sdata      (rxd_q),
        .meter_done (meter_done[IDX_RX]),
        .meter_width(meter_width[IDX_RX]),
        .word       (rx_word),
        .valid      (rx_valid),
        .lsb_lost   (rx_lsb_lost)
    );

    assign tx_slot_n = ~tx_oe;
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_oe,
    input logic tx_sdata,
    input logic rx_valid,
    input logic rx_lsb_lost,
    input logic bclk_rise,
    input logic bclk_fall,
    input logic txfs_rise,
    input logic txfs_fall,
    input logic txfs_lvl,
    input logic sync_mode
);
    AST_OE_ON_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe) |-> $past(bclk_rise || txfs_rise)); // R4

    AST_OE_OFF_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_oe) |-> $past(bclk_fall || !txfs_lvl)); // R5

    AST_DATA_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe && $past(tx_oe) && !$past(bclk_rise)) |-> $stable(tx_sdata)); // R3

    AST_MODE_AT_SYNC_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_mode) |-> $past(txfs_fall)); // R6

    AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(bclk_fall)); // R7

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R9

    AST_LOST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_lsb_lost) |-> rx_valid); // R10
endmodule

bind pcm_serial_port pcm_serial_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_oe      (tx_oe),
    .tx_sdata   (tx_sdata),
    .rx_valid   (rx_valid),
    .rx_lsb_lost(rx_lsb_lost),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .txfs_rise  (txfs_rise),
    .txfs_fall  (txfs_fall),
    .txfs_lvl   (txfs_lvl),
    .sync_mode  (sync_mode)
);

// File: tb/pcm_serial_port_bench.sv
module pcm_serial_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b0, tx_fs = 1'b0, rx_fs = 1'b0, rx_sdata = 1'b0;
    logic [7:0] tx_word = 8'h00;
    logic       tx_sdata, tx_oe, tx_slot_n, rx_valid, rx_lsb_lost;
    logic [7:0] rx_word;

    int tests = 0, fails = 0;
    int vcount = 0;
    logic [7:0] vbyte = 8'h00;
    logic       vlost = 1'b0;

    always #5 clk = ~clk;

    pcm_serial_port u_pcm_serial_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .tx_fs(tx_fs), .rx_fs(rx_fs),
        .rx_sdata(rx_sdata), .tx_word(tx_word), .tx_sdata(tx_sdata),
        .tx_oe(tx_oe), .tx_slot_n(tx_slot_n), .rx_word(rx_word),
        .rx_valid(rx_valid), .rx_lsb_lost(rx_lsb_lost)
    );

    // One frame = 40 half bit periods; even halves start with bclk rising
    typedef struct packed {
        logic [7:0]  word;
        logic [7:0]  rxb;
        logic [39:0] txm;
        logic [39:0] rxm;
        logic [5:0]  en;
        logic [5:0]  dis;
        logic        rxfirst;
        logic        lost;
        logic        lng;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{8'hA5, 8'h3C, 40'h3,     40'h3,   6'd2, 6'd17, 1'b1, 1'b0, 1'b0}, // short
        '{8'h5A, 8'hC3, 40'h3F,    40'h3F,  6'd2, 6'd17, 1'b1, 1'b0, 1'b0}, // long pulse, still short
        '{8'h81, 8'h7E, 40'h3F,    40'h3F,  6'd0, 6'd15, 1'b0, 1'b0, 1'b1}, // long
        '{8'h6D, 8'h5B, 40'hF,     40'hF,   6'd0, 6'd15, 1'b0, 1'b1, 1'b1}, // 2-wide: mode kept, LSB lost
        '{8'hF0, 8'h0F, 40'hFFFFF, 40'h3F,  6'd0, 6'd20, 1'b0, 1'b0, 1'b1}, // sync outlasts slot
        '{8'h3C, 8'h96, 40'h1FE,   40'h1FE, 6'd2, 6'd17, 1'b1, 1'b0, 1'b1}, // sync rises with bclk low
        '{8'hC9, 8'h24, 40'h3,     40'h3,   6'd0, 6'd15, 1'b0, 1'b0, 1'b1}, // 1-wide in long mode
        '{8'h17, 8'hE8, 40'h3,     40'h3,   6'd2, 6'd17, 1'b1, 1'b0, 1'b0}  // back to short
    };

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount = vcount + 1;
            vbyte  = rx_word;
            vlost  = rx_lsb_lost;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic b, input logic tf, input logic rf, input logic d);
        bclk = b; tx_fs = tf; rx_fs = rf; rx_sdata = d;
        repeat (3) @(negedge clk);
    endtask

    task automatic run_frame(input vec_t v);
        string tag;
        tag = v.lng ? "R4/R5/R6/R12" : "R2/R3/R6/R12";
        tx_word = v.word;
        vcount  = 0;
        for (int h = 0; h < 40; h++) begin
            int  p, k;
            logic d, exp_oe;
            p = h / 2;
            k = p - int'(v.rxfirst);
            d = (k >= 0 && k < 8) ? v.rxb[7-k] : 1'b0;
            if (h == int'(v.en) + 1) tx_word = ~v.word;
            drive(h % 2 == 0, v.txm[h], v.rxm[h], d);
            exp_oe = (h >= int'(v.en)) && (h < int'(v.dis));
            check(tx_oe == exp_oe, tag, tx_oe, exp_oe);
            check(tx_slot_n == !tx_oe, "R11", tx_slot_n, !tx_oe);
            if (exp_oe && tx_oe) begin
                int b = 0;
                for (int e = int'(v.en) + 1; e <= h; e++) if (e % 2 == 0) b++;
                if (b > 7) b = 7;
                check(tx_sdata == v.word[7-b], tag, tx_sdata, v.word[7-b]);
            end
            @(negedge clk);
        end
        check(vcount == 1, "R9", vcount, 1);
        check(vbyte == v.rxb, v.rxfirst ? "R7/R9" : "R8/R9", vbyte, v.rxb);
        check(vlost == v.lost, "R10", vlost, v.lost);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(tx_oe == 1'b0, "R1", tx_oe, 0);
        check(tx_slot_n == 1'b1, "R1", tx_slot_n, 1);
        check(rx_valid == 1'b0 && rx_lsb_lost == 1'b0, "R1", {rx_valid, rx_lsb_lost}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int i = 0; i < 8; i++) run_frame(VEC[i]);

        // Directed: reset in the middle of a long-mode slot
        run_frame(VEC[1]);                    // leaves mode long
        tx_word = 8'hFF;
        for (int h = 0; h < 6; h++) begin
            drive(h % 2 == 0, 1'b1, 1'b0, 1'b0);
            @(negedge clk);
        end
        check(tx_oe == 1'b1, "R4", tx_oe, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_oe == 1'b0 && tx_slot_n == 1'b1, "R1", {tx_oe, tx_slot_n}, 1);
        rst_n = 1'b1;
        for (int h = 6; h < 40; h++) begin
            drive(h % 2 == 0, 1'b0, 1'b0, 1'b0);
            check(tx_oe == 1'b0, "R1", tx_oe, 0);
            @(negedge clk);
        end
        // After reset the mode is short again: long pulse behaves as short (R1, R6)
        run_frame(VEC[1]);
        run_frame(VEC[2]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule